// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block sits between a serial command front-end and a byte-wide nonvolatile array. Once the front-end has decoded a write command and its start address, it passes the payload bytes in one at a time. The block stores each byte in a page buffer at an offset inside the addressed page. The offset advances after every byte and wraps at the page edge, so a long burst overwrites its own oldest bytes. A per-slot valid flag records which offsets the burst has touched.

When chip select rises, the front-end reports whether that rise came on a whole-byte boundary. The block starts a commit only if four things hold: the rise is aligned, at least one byte was loaded, the write-enable latch is set, and the protection check for the target page passes. During the commit, a busy flag is held for a fixed number of system clocks, which stands in for the nominal 10 ms program time. While busy, the valid slots are written to the array one per clock in ascending offset order. At the end a one-cycle completion pulse tells the status logic that it may clear its write-enable latch.

Top module: `pwb_top`

## Requirements
- R1: During and right after reset, `busy_o`, `wr_done_o` and `arr_we_o` are 0.
- R2: A command taken on `cmd_start_i` sets the target page to `cmd_addr_i[ADDR_W-1:5]`, which is shown on `tgt_page_o` from the next cycle. It also sets the byte offset to `cmd_addr_i[4:0]`. Each byte is committed to array address {page, offset}.
- R3: After each byte, only the 5-bit offset advances, so offset 31 is followed by offset 0 of the same page.
- R4: If more than 32 bytes are loaded, each offset holds the most recent byte loaded there, so only the last 32 bytes are committed.
- R5: Only offsets that received a byte in the current command are written. The other locations of the page see no array write.
- R6: A chip-select rise with `cs_aligned_i` = 0 cancels the command. It produces no busy period and no array write.
- R7: A commit needs `wel_i` = 1, `page_prot_i` = 0 and at least one loaded byte at the chip-select rise. Otherwise the command is dropped.
- R8: After a committing rise, `busy_o` goes to 1 in the next cycle and stays at 1 for exactly WR_CYCLES cycles. Array writes occur only in the first 32 busy cycles, where busy cycle k writes offset k.
- R9: `wr_done_o` pulses for exactly one cycle, which is the first cycle in which `busy_o` is 0 again.
- R10: While `busy_o` is 1, `cmd_start_i`, data bytes and chip-select rises are ignored. They cause no write and do not extend busy.
- R11: A byte presented in the same cycle as the chip-select rise counts as the last byte of the command.
- R12: A `cmd_start_i` in the cycle where `wr_done_o` is 1 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_start_i | input | 1 | Write command decoded, address valid |
| cmd_addr_i | input | ADDR_W | Start byte address |
| byte_vld_i | input | 1 | Complete payload byte available |
| byte_i | input | 8 | Payload byte |
| cs_rise_i | input | 1 | Chip select has gone inactive |
| cs_aligned_i | input | 1 | That rise fell on a byte boundary |
| wel_i | input | 1 | Write-enable latch state |
| page_prot_i | input | 1 | Target page is protected |
| tgt_page_o | output | ADDR_W-5 | Page of the current command |
| busy_o | output | 1 | Self-timed write in progress |
| wr_done_o | output | 1 | One-cycle completion pulse |
| arr_we_o | output | 1 | Array byte write strobe |
| arr_addr_o | output | ADDR_W | Array byte address |
| arr_data_o | output | 8 | Array byte data |

## Verification
Two pairs of events can land in the same cycle. In the first, the final payload byte and the chip-select rise arrive together. The bench drives both strobes in one cycle and requires that byte to be committed at the next offset. In the second, the completion pulse coincides with a fresh write command. The bench waits for `wr_done_o` and issues `cmd_start_i` in that very cycle, and it judges the outcome by whether the following commit writes its byte. A behavioural model advanced on every clock also compares busy, done, strobe, address and data in every cycle, so an accepted or ignored event that lands one cycle off shows up as a mismatch.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf
  import pwb_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [OFF_W-1:0] base_i,
  input  logic             wr_i,
  input  byte_t            data_i,
  input  logic             frz_i,
  input  logic [OFF_W-1:0] rd_slot_i,
  output byte_t            rd_data_o,
  output logic             rd_vld_o,
  output logic             any_o
);

  logic [OFF_W-1:0]      ptr_q;
  logic [PAGE_BYTES-1:0] vld_q;
  byte_t                 data_q [PAGE_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (clr_i) begin
      ptr_q <= base_i;
    end else if (wr_i) begin
      ptr_q <= ptr_q + 1'b1;  // wraps inside the page
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_i && !clr_i && (ptr_q == OFF_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
      end else if (clr_i) begin
        vld_q[g] <= 1'b0;
      end else if (hit) begin
        vld_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (hit) data_q[g] <= data_i;
    end
  end

  assign rd_data_o = data_q[rd_slot_i];
  assign rd_vld_o  = vld_q[rd_slot_i];
  assign any_o     = (|vld_q) || wr_i;

  // buffer contents must not move under a running commit
  assert_buf_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frz_i) |-> $stable(vld_q));

endmodule

// File: rtl/pwb_wr_seq.sv
module pwb_wr_seq #(
  parameter int unsigned TOTAL      = 500000,
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned OFF_W      = $clog2(PAGE_BYTES),
  parameter int unsigned CNT_W      = $clog2(TOTAL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             slot_act_o,
  output logic [OFF_W-1:0] slot_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (cnt_q == CNT_W'(TOTAL - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign slot_act_o = busy_q && (cnt_q < CNT_W'(PAGE_BYTES));
  assign slot_o     = cnt_q[OFF_W-1:0];

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_no_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);

endmodule

// File: rtl/pwb_top.sv
module pwb_top
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned WR_CYCLES  = 500000,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
  localparam int unsigned PAGE_W    = ADDR_W - OFF_W,
  localparam int unsigned TOTAL     = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_start_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              byte_vld_i,
  input  byte_t             byte_i,
  input  logic              cs_rise_i,
  input  logic              cs_aligned_i,
  input  logic              wel_i,
  input  logic              page_prot_i,
  output logic [PAGE_W-1:0] tgt_page_o,
  output logic              busy_o,
  output logic              wr_done_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output byte_t             arr_data_o
);

  logic              loading_q;
  logic [PAGE_W-1:0] page_q;
  logic              busy;
  logic              accept_cmd, take_byte, commit;
  logic              any_loaded;
  logic              slot_act, slot_vld;
  logic [OFF_W-1:0]  slot;
  byte_t             slot_data;

  assign accept_cmd = cmd_start_i && !busy;
  assign take_byte  = byte_vld_i && loading_q && !busy && !cmd_start_i;
  // a byte in the rise cycle is already counted by any_loaded
  assign commit     = cs_rise_i && loading_q && !busy && cs_aligned_i &&
                      any_loaded && wel_i && !page_prot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loading_q <= 1'b0;
      page_q    <= '0;
    end else if (accept_cmd) begin
      loading_q <= 1'b1;
      page_q    <= cmd_addr_i[ADDR_W-1:OFF_W];
    end else if (cs_rise_i) begin
      loading_q <= 1'b0;
    end
  end

  pwb_page_buf #(
    .PAGE_BYTES (PAGE_BYTES),
    .OFF_W      (OFF_W)
  ) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept_cmd),
    .base_i    (cmd_addr_i[OFF_W-1:0]),
    .wr_i      (take_byte),
    .data_i    (byte_i),
    .frz_i     (busy),
    .rd_slot_i (slot),
    .rd_data_o (slot_data),
    .rd_vld_o  (slot_vld),
    .any_o     (any_loaded)
  );

  pwb_wr_seq #(
    .TOTAL      (TOTAL),
    .PAGE_BYTES (PAGE_BYTES),
    .OFF_W      (OFF_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (commit),
    .busy_o     (busy),
    .done_o     (wr_done_o),
    .slot_act_o (slot_act),
    .slot_o     (slot)
  );

  assign busy_o     = busy;
  assign tgt_page_o = page_q;
  assign arr_we_o   = slot_act && slot_vld;
  assign arr_addr_o = {page_q, slot};
  assign arr_data_o = slot_data;

  assert_we_in_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o);

  assert_busy_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_rise_i && cs_aligned_i && wel_i && !page_prot_i));

  assert_done_after_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: tb/pwb_top_tb_top.sv
module pwb_top_tb_top;
  localparam int WR = 40;
  localparam int PB = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_start = 1'b0;
  logic [11:0] cmd_addr = '0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_d = '0;
  logic       cs_rise = 1'b0;
  logic       cs_aligned = 1'b0;
  logic       wel = 1'b1;
  logic       prot = 1'b0;
  logic [6:0] tgt_page;
  logic       busy_o, wr_done_o, arr_we_o;
  logic [11:0] arr_addr_o;
  logic [7:0] arr_data_o;

  always #5 clk = ~clk;

  pwb_top #(.ADDR_W(12), .PAGE_BYTES(PB), .WR_CYCLES(WR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_start_i(cmd_start), .cmd_addr_i(cmd_addr),
    .byte_vld_i(byte_vld), .byte_i(byte_d), .cs_rise_i(cs_rise),
    .cs_aligned_i(cs_aligned), .wel_i(wel), .page_prot_i(prot),
    .tgt_page_o(tgt_page), .busy_o(busy_o), .wr_done_o(wr_done_o),
    .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o), .arr_data_o(arr_data_o));

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit  m_busy, m_done, m_loading;
  int  m_el, m_page, m_ptr;
  int  m_buf [PB];
  bit  m_vld [PB];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_loading = 0; m_el = 0; m_page = 0; m_ptr = 0;
      foreach (m_vld[i]) m_vld[i] = 0;
    end else begin
      bit old_busy;
      old_busy = m_busy;
      m_done = 0;
      if (old_busy) begin
        if (m_el == WR - 1) begin m_busy = 0; m_done = 1; end
        else m_el++;
      end else if (cmd_start) begin
        m_loading = 1; m_page = cmd_addr / PB; m_ptr = cmd_addr % PB;
        foreach (m_vld[i]) m_vld[i] = 0;
      end else begin
        if (byte_vld && m_loading) begin
          m_buf[m_ptr] = byte_d; m_vld[m_ptr] = 1; m_ptr = (m_ptr + 1) % PB;
        end
        if (cs_rise) begin
          bit any;
          any = 0;
          foreach (m_vld[i]) if (m_vld[i]) any = 1;
          if (m_loading && cs_aligned && any && wel && !prot) begin
            m_busy = 1; m_el = 0;
          end
          m_loading = 0;
        end
      end
      if (old_busy) m_loading = 0;
    end
  end

  // monitor: array image, counters, per-cycle comparison
  logic [7:0] arr [4096];
  int wr_cnt = 0, busy_rises = 0, done_cnt = 0, run = 0, last_len = 0;
  bit prev_busy = 0;

  initial foreach (arr[i]) arr[i] = 8'h5A;

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_we;
      exp_we = m_busy && (m_el < PB) && m_vld[m_el % PB];
      chk("R8", "busy", busy_o, m_busy);
      chk("R9", "done", wr_done_o, m_done);
      chk("R5", "we", arr_we_o, exp_we);
      chk("R2", "tgt_page", tgt_page, m_page);
      if (exp_we && arr_we_o) begin
        chk("R2", "addr", arr_addr_o, m_page * PB + m_el);
        chk("R4", "data", arr_data_o, m_buf[m_el]);
      end
      if (arr_we_o) begin arr[arr_addr_o] = arr_data_o; wr_cnt++; end
      if (wr_done_o) done_cnt++;
      if (busy_o && !prev_busy) busy_rises++;
      if (busy_o) run++;
      if (!busy_o && prev_busy) begin last_len = run; run = 0; end
      prev_busy = busy_o;
    end
  end

  task automatic do_cmd(input logic [11:0] a);
    cmd_start = 1; cmd_addr = a; @(negedge clk); cmd_start = 0;
  endtask
  task automatic send_byte(input logic [7:0] d);
    byte_vld = 1; byte_d = d; @(negedge clk); byte_vld = 0;
  endtask
  task automatic cs_up(input logic al, input logic wb, input logic [7:0] d);
    cs_rise = 1; cs_aligned = al; byte_vld = wb; byte_d = d;
    @(negedge clk);
    cs_rise = 0; cs_aligned = 0; byte_vld = 0;
  endtask
  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", busy_o, 0);
    chk("R1", "done in reset", wr_done_o, 0);
    chk("R1", "we in reset", arr_we_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "busy after reset", busy_o, 0);
    chk("R1", "we after reset", arr_we_o, 0);

    // basic three-byte write
    w0 = wr_cnt;
    do_cmd(12'h123);
    chk("R2", "page latched", tgt_page, 7'h09);
    send_byte(8'hA0); send_byte(8'hA1); send_byte(8'hA2);
    cs_up(1, 0, 0);
    chk("R8", "busy after rise", busy_o, 1);
    wait_idle();
    chk("R2", "arr 123", arr[12'h123], 8'hA0);
    chk("R2", "arr 125", arr[12'h125], 8'hA2);
    chk("R5", "arr 122 untouched", arr[12'h122], 8'h5A);
    chk("R5", "arr 126 untouched", arr[12'h126], 8'h5A);
    chk("R5", "write count", wr_cnt - w0, 3);
    chk("R8", "busy length", last_len, WR);
    chk("R9", "done count", done_cnt, 1);

    // wrap at page edge
    do_cmd(12'h23E);
    send_byte(8'hB0); send_byte(8'hB1); send_byte(8'hB2); send_byte(8'hB3);
    cs_up(1, 0, 0);
    wait_idle();
    chk("R3", "arr 23F", arr[12'h23F], 8'hB1);
    chk("R3", "arr 220", arr[12'h220], 8'hB2);
    chk("R3", "arr 221", arr[12'h221], 8'hB3);
    chk("R3", "arr 240 untouched", arr[12'h240], 8'h5A);

    // 34 bytes: last 32 kept
    w0 = wr_cnt;
    do_cmd(12'h300);
    for (int i = 0; i < 34; i++) send_byte(8'(8'h40 + i));
    cs_up(1, 0, 0);
    wait_idle();
    chk("R4", "arr 300", arr[12'h300], 8'h60);
    chk("R4", "arr 301", arr[12'h301], 8'h61);
    chk("R4", "arr 302", arr[12'h302], 8'h42);
    chk("R4", "arr 31F", arr[12'h31F], 8'h5F);
    chk("R4", "write count", wr_cnt - w0, 32);

    // misaligned rise
    do_cmd(12'h400); send_byte(8'hC0); cs_up(0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R6", "no busy", busy_o, 0);
    chk("R6", "arr 400", arr[12'h400], 8'h5A);

    // write-enable clear, protected page, empty command
    wel = 0;
    do_cmd(12'h410); send_byte(8'hC1); cs_up(1, 0, 0);
    repeat (3) @(negedge clk);
    chk("R7", "wel=0 no busy", busy_o, 0);
    wel = 1; prot = 1;
    do_cmd(12'h420); send_byte(8'hC2); cs_up(1, 0, 0);
    repeat (3) @(negedge clk);
    chk("R7", "prot no busy", busy_o, 0);
    prot = 0;
    do_cmd(12'h430); cs_up(1, 0, 0);
    repeat (3) @(negedge clk);
    chk("R7", "empty no busy", busy_o, 0);
    chk("R7", "arr 410", arr[12'h410], 8'h5A);
    chk("R7", "arr 420", arr[12'h420], 8'h5A);
    chk("R7", "rises so far", busy_rises, 3);

    // last byte with the rise
    do_cmd(12'h500); send_byte(8'hD0); cs_up(1, 1, 8'hD1);
    // traffic while busy
    do_cmd(12'h600); send_byte(8'hE0); cs_up(1, 0, 0);
    chk("R10", "still busy", busy_o, 1);
    // command in the done cycle
    while (!wr_done_o) @(negedge clk);
    do_cmd(12'h700); send_byte(8'hF0); cs_up(1, 0, 0);
    wait_idle();
    chk("R11", "arr 500", arr[12'h500], 8'hD0);
    chk("R11", "arr 501", arr[12'h501], 8'hD1);
    chk("R10", "arr 600", arr[12'h600], 8'h5A);
    chk("R12", "arr 700", arr[12'h700], 8'hF0);
    chk("R12", "rises", busy_rises, 5);
    chk("R9", "done count", done_cnt, 5);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule